// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM from power-up to normal operation. After a start pulse it walks a fixed list of fifteen memory commands, offering each one on a valid/ready command port. Between commands it waits out the long power-up settle time and a short gap after every mode-register write. Along the way it drives two control bits that the command path folds into the mode-register data: one that requests a DLL reset and one that selects the OCD default setting.

The configuration arrives on static inputs: a column-width field, a row-width field, an interleaved-decode flag, a narrow-bus flag and a refresh-rate value. From the first four the block works out where the bank bits sit in the system address. Each extended mode-register write is then addressed at its bank number shifted to that position. After the final dummy write the block pulses a load strobe that hands the refresh-rate value to the refresh engine. It then raises `done` and keeps it high until reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `cmd_valid`, `refresh_load` and `done` are 0 and `refresh_out` is 0.
- R2: The commands are offered in this order, with codes NORMAL=0, NOP=1, PRECHARGE=2, LMR=3, REFRESH=4, EMRS=5, WRITE=6: NOP, NOP, PRECHARGE, EMRS bank 2, EMRS bank 3, EMRS bank 1, LMR, PRECHARGE, REFRESH, REFRESH, LMR, EMRS bank 1, EMRS bank 1, NORMAL, WRITE. No further command follows.
- R3: The bank shift is `col_sel + 9`. When `interleave` is 0, `row_sel + 11` is added to it. Finally 1 is added if `narrow_bus` is 1, or 2 if it is 0. An EMRS command carries `cmd_addr = bank << shift`; every other command carries `cmd_addr = 0`.
- R4: After the first NOP is accepted, `cmd_valid` stays low for exactly `CLK_MHZ*200` cycles before the second NOP is offered.
- R5: An offered command stays valid, with unchanged code and address, until a cycle in which `cmd_ready` is 1.
- R6: After an LMR or EMRS is accepted, `cmd_valid` stays low for exactly `TMRD_CYC` cycles. Every other command, except the first NOP, is followed in the very next cycle by the next command.
- R7: `dll_rst` is 1 while the first LMR, the second PRECHARGE and both REFRESH commands are offered, and 0 while any other command is offered.
- R8: `ocd_dflt` is 1 only while the first of the last two EMRS bank 1 commands is offered.
- R9: In the cycle after the WRITE is accepted, `refresh_load` is 1 for one cycle and `refresh_out` equals `refresh_val`. In the cycle after that, `done` is 1.
- R10: Once `done` is 1 it stays 1 and no further command is offered until reset. A `start` pulse while the sequence runs or after it has finished has no effect.
- R11: The sequencer stays idle, with `cmd_valid` at 0, until a `start` pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| col_sel | input | 2 | Column-width field |
| row_sel | input | 2 | Row-width field |
| interleave | input | 1 | 1 = interleaved bank decode (row term omitted) |
| narrow_bus | input | 1 | 1 = narrow data bus |
| refresh_val | input | REF_W | Refresh-rate value to hand over at the end |
| cmd_ready | input | 1 | Command port accepts the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd_code | output | 3 | Command code |
| cmd_addr | output | ADDR_W | Address; bank bits for EMRS |
| dll_rst | output | 1 | DLL-reset control bit |
| ocd_dflt | output | 1 | OCD-default control bit |
| refresh_load | output | 1 | One-cycle load strobe for the refresh rate |
| refresh_out | output | REF_W | Refresh-rate value handed over |
| done | output | 1 | Initialization complete |

## Verification
Several properties are checked on every cycle. A stalled command must hold still. A command other than EMRS must carry a zero address. The port must go quiet right after a mode-register write. The two control bits must never be high together. The load strobe must be followed by a sticky `done` that blocks any further command. The exact command order, the bank-shifted addresses for each configuration, the exact lengths of the power-up and mode-register gaps, and the windows in which `dll_rst` and `ocd_dflt` are high can only be shown by the bench scenarios. Those scenarios compare the port cycle by cycle against a model built from the requirements, under an always-ready port and under random stalls.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL    = 3'd0,
        CMD_NOP       = 3'd1,
        CMD_PRECHARGE = 3'd2,
        CMD_LMR       = 3'd3,
        CMD_REFRESH   = 3'd4,
        CMD_EMRS      = 3'd5,
        CMD_WRITE     = 3'd6
    } cmd_e;

    typedef struct packed {
        cmd_e       code;
        logic [1:0] bank;
        logic       dll;
        logic       ocd;
        logic       mode_reg;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_PWR_WAIT,
        ST_GAP,
        ST_LOAD,
        ST_DONE
    } seq_state_e;

    localparam int NUM_STEPS = 15;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int SHIFT_W   = 5;

    function automatic step_t mk_step(cmd_e c, logic [1:0] b, logic d, logic o);
        step_t s;
        s.code     = c;
        s.bank     = b;
        s.dll      = d;
        s.ocd      = o;
        s.mode_reg = (c == CMD_LMR) || (c == CMD_EMRS);
        return s;
    endfunction

    // Fixed bring-up order; index is the position in the sequence.
    function automatic step_t step_lookup(logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = mk_step(CMD_NOP,       2'd0, 1'b0, 1'b0);
            4'd1:    s = mk_step(CMD_NOP,       2'd0, 1'b0, 1'b0);
            4'd2:    s = mk_step(CMD_PRECHARGE, 2'd0, 1'b0, 1'b0);
            4'd3:    s = mk_step(CMD_EMRS,      2'd2, 1'b0, 1'b0);
            4'd4:    s = mk_step(CMD_EMRS,      2'd3, 1'b0, 1'b0);
            4'd5:    s = mk_step(CMD_EMRS,      2'd1, 1'b0, 1'b0);
            4'd6:    s = mk_step(CMD_LMR,       2'd0, 1'b1, 1'b0);
            4'd7:    s = mk_step(CMD_PRECHARGE, 2'd0, 1'b1, 1'b0);
            4'd8:    s = mk_step(CMD_REFRESH,   2'd0, 1'b1, 1'b0);
            4'd9:    s = mk_step(CMD_REFRESH,   2'd0, 1'b1, 1'b0);
            4'd10:   s = mk_step(CMD_LMR,       2'd0, 1'b0, 1'b0);
            4'd11:   s = mk_step(CMD_EMRS,      2'd1, 1'b0, 1'b1);
            4'd12:   s = mk_step(CMD_EMRS,      2'd1, 1'b0, 1'b0);
            4'd13:   s = mk_step(CMD_NORMAL,    2'd0, 1'b0, 1'b0);
            4'd14:   s = mk_step(CMD_WRITE,     2'd0, 1'b0, 1'b0);
            default: s = mk_step(CMD_NOP,       2'd0, 1'b0, 1'b0);
        endcase
        return s;
    endfunction

    // Position of the bank bits in the system address.
    function automatic logic [SHIFT_W-1:0] bank_shift(
        logic [1:0] col, logic [1:0] row, logic interleaved, logic narrow);
        logic [SHIFT_W-1:0] sh;
        sh = SHIFT_W'(col) + SHIFT_W'(9);
        if (!interleaved)
            sh = sh + SHIFT_W'(row) + SHIFT_W'(11);
        sh = sh + (narrow ? SHIFT_W'(1) : SHIFT_W'(2));
        return sh;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr2_bank_addr.sv
module ddr2_bank_addr
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        col_sel,
    input  logic [1:0]        row_sel,
    input  logic              interleave,
    input  logic              narrow_bus,
    input  logic              is_emrs,
    input  logic [1:0]        bank,
    output logic [ADDR_W-1:0] addr
);
    logic [SHIFT_W-1:0] shift;

    always_comb begin
        shift = bank_shift(col_sel, row_sel, interleave, narrow_bus);
        addr  = is_emrs ? (ADDR_W'(bank) << shift) : '0;
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int TMRD_CYC = 2,
    parameter int ADDR_W   = 32,
    parameter int REF_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        col_sel,
    input  logic [1:0]        row_sel,
    input  logic              interleave,
    input  logic              narrow_bus,
    input  logic [REF_W-1:0]  refresh_val,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              dll_rst,
    output logic              ocd_dflt,
    output logic              refresh_load,
    output logic [REF_W-1:0]  refresh_out,
    output logic              done
);
    localparam int PWRUP_CYC = CLK_MHZ * 200;
    localparam int DLY_MAX   = (PWRUP_CYC > TMRD_CYC) ? PWRUP_CYC : TMRD_CYC;
    localparam int TMR_W     = $clog2(DLY_MAX + 1);
    localparam int LAST_STEP = NUM_STEPS - 1;

    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [REF_W-1:0]  rate_q;
    step_t             cur;
    logic              accept, active;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;

    assign cur    = step_lookup(step_q);
    assign accept = (state_q == ST_ISSUE) && cmd_ready;
    assign active = (state_q == ST_ISSUE) || (state_q == ST_PWR_WAIT) || (state_q == ST_GAP);

    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_ISSUE;
                    step_d  = '0;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (step_q == STEP_W'(LAST_STEP)) begin
                        state_d = ST_LOAD;
                    end else if (step_q == '0) begin
                        state_d  = ST_PWR_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(PWRUP_CYC - 1);
                    end else if (cur.mode_reg) begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(TMRD_CYC - 1);
                    end else begin
                        step_d = step_q + STEP_W'(1);
                    end
                end
            end
            ST_PWR_WAIT, ST_GAP: begin
                if (tmr_expired) begin
                    state_d = ST_ISSUE;
                    step_d  = step_q + STEP_W'(1);
                end
            end
            ST_LOAD:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (accept && step_q == STEP_W'(LAST_STEP))
                rate_q <= refresh_val;
        end
    end

    ddr2_init_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ddr2_bank_addr #(.ADDR_W(ADDR_W)) i_bank_addr (
        .col_sel    (col_sel),
        .row_sel    (row_sel),
        .interleave (interleave),
        .narrow_bus (narrow_bus),
        .is_emrs    (cur.code == CMD_EMRS),
        .bank       (cur.bank),
        .addr       (cmd_addr)
    );

    assign cmd_valid    = (state_q == ST_ISSUE);
    assign cmd_code     = cur.code;
    assign dll_rst      = active && cur.dll;
    assign ocd_dflt     = active && cur.ocd;
    assign refresh_load = (state_q == ST_LOAD);
    assign refresh_out  = rate_q;
    assign done         = (state_q == ST_DONE);
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              cmd_ready,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              dll_rst,
    input logic              ocd_dflt,
    input logic              refresh_load,
    input logic              done
);
    localparam logic [2:0] C_LMR  = 3'd3;
    localparam logic [2:0] C_EMRS = 3'd5;

    p_hold_stalled_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr));

    p_addr_zero_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code != C_EMRS |-> cmd_addr == '0);

    p_quiet_after_mr_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && (cmd_code == C_LMR || cmd_code == C_EMRS) |=> !cmd_valid);

    p_bits_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(dll_rst && ocd_dflt));

    p_load_then_done_r9: assert property (@(posedge clk) disable iff (rst)
        refresh_load |=> done && !refresh_load);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_silent_when_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid && !refresh_load);

    p_start_ignored_done_r10: assert property (@(posedge clk) disable iff (rst)
        done && start |=> done && !cmd_valid);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cmd_ready    (cmd_ready),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .cmd_addr     (cmd_addr),
    .dll_rst      (dll_rst),
    .ocd_dflt     (ocd_dflt),
    .refresh_load (refresh_load),
    .done         (done)
);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;
    localparam int CLK_MHZ = 1;
    localparam int TMRD    = 3;
    localparam int PWR     = CLK_MHZ * 200;
    localparam int AW      = 32;
    localparam int RW      = 12;
    localparam int NCMD    = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    col_sel = '0, row_sel = '0;
    logic          interleave = 1'b0, narrow_bus = 1'b0;
    logic [RW-1:0] refresh_val = '0;
    logic          cmd_ready = 1'b0;
    logic          cmd_valid;
    logic [2:0]    cmd_code;
    logic [AW-1:0] cmd_addr;
    logic          dll_rst, ocd_dflt, refresh_load, done;
    logic [RW-1:0] refresh_out;

    always #2 clk = ~clk;

    ddr2_init_seq #(.CLK_MHZ(CLK_MHZ), .TMRD_CYC(TMRD), .ADDR_W(AW), .REF_W(RW)) i_ddr2_init_seq (
        .clk(clk), .rst(rst), .start(start), .col_sel(col_sel), .row_sel(row_sel),
        .interleave(interleave), .narrow_bus(narrow_bus), .refresh_val(refresh_val),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .dll_rst(dll_rst), .ocd_dflt(ocd_dflt), .refresh_load(refresh_load),
        .refresh_out(refresh_out), .done(done));

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected command list written from the requirements.
    function automatic void exp_step(input int i, output int code, output int bank,
                                     output bit dll, output bit ocd);
        int codes[NCMD] = '{1, 1, 2, 5, 5, 5, 3, 2, 4, 4, 3, 5, 5, 0, 6};
        int banks[NCMD] = '{0, 0, 0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0};
        code = codes[i];
        bank = banks[i];
        dll  = (i >= 6 && i <= 9);
        ocd  = (i == 11);
    endfunction

    function automatic longint exp_addr(input int i);
        int code, bank, sh;
        bit d, o;
        exp_step(i, code, bank, d, o);
        sh = int'(col_sel) + 9 + (interleave ? 0 : int'(row_sel) + 11) + (narrow_bus ? 1 : 2);
        return (code == 5) ? (longint'(bank) << sh) : 0;
    endfunction

    // Reference model state
    bit     mon_en = 0;
    int     idx, gap, exp_gap, load_stage, ready_mode;
    bit     gap_open, prev_stall;
    logic [31:0] lfsr = 32'h1234_5678;

    always @(negedge clk) begin
        if (mon_en) begin
            int code, bank;
            bit d, o;
            if (load_stage == 1) begin
                chk(refresh_load == 1'b1, "R9", "refresh_load pulse", refresh_load, 1);
                chk(refresh_out == refresh_val, "R9", "refresh_out", refresh_out, refresh_val);
                load_stage = 2;
            end else if (load_stage == 2) begin
                chk(done == 1'b1 && refresh_load == 1'b0, "R9", "done after load",
                    {done, refresh_load}, 2'b10);
                load_stage = 3;
            end
            if (prev_stall)
                chk(cmd_valid == 1'b1, "R5", "command dropped while stalled", cmd_valid, 1);
            if (cmd_valid) begin
                if (idx >= NCMD) begin
                    chk(0, "R2", "extra command", cmd_code, 0);
                end else begin
                    if (gap_open) begin
                        chk(gap == exp_gap, (idx == 1) ? "R4" : "R6", "idle cycles before command",
                            gap, exp_gap);
                        gap_open = 0;
                    end
                    exp_step(idx, code, bank, d, o);
                    chk(int'(cmd_code) == code, "R2", "command code", cmd_code, code);
                    chk(longint'(cmd_addr) == exp_addr(idx), "R3", "command address",
                        cmd_addr, exp_addr(idx));
                    chk(dll_rst == d, "R7", "dll_rst", dll_rst, d);
                    chk(ocd_dflt == o, "R8", "ocd_dflt", ocd_dflt, o);
                end
            end else if (gap_open) begin
                gap++;
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cmd_ready = (ready_mode == 0) ? 1'b1 : (lfsr[3] & lfsr[7]) | lfsr[11];
            prev_stall = cmd_valid && !cmd_ready;
            if (cmd_valid && cmd_ready && idx < NCMD) begin
                exp_step(idx, code, bank, d, o);
                exp_gap = (idx == 0) ? PWR : ((code == 3 || code == 5) ? TMRD : 0);
                idx++;
                gap      = 0;
                gap_open = (idx < NCMD);
                if (idx == NCMD) load_stage = 1;
            end
        end
    end

    task automatic run_cfg(input logic [1:0] c, input logic [1:0] r, input bit il,
                           input bit nb, input logic [RW-1:0] rv, input int rmode);
        col_sel = c; row_sel = r; interleave = il; narrow_bus = nb; refresh_val = rv;
        @(negedge clk);
        rst = 1'b1; start = 1'b0; cmd_ready = 1'b0; mon_en = 0;
        repeat (3) @(negedge clk);
        chk(cmd_valid == 0 && done == 0 && refresh_load == 0 && refresh_out == 0,
            "R1", "state in reset", {cmd_valid, done, refresh_load}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 0 && done == 0 && refresh_out == 0, "R1", "state after reset",
            {cmd_valid, done}, 0);
        repeat (6) begin
            @(negedge clk);
            chk(cmd_valid == 0, "R11", "idle without start", cmd_valid, 0);
        end
        idx = 0; gap = 0; exp_gap = 0; load_stage = 0; gap_open = 0; prev_stall = 0;
        ready_mode = rmode;
        mon_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;   // during power-up wait: must be ignored (R10)
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 4000 && load_stage != 3; t++) @(negedge clk);
        start = 1'b1;   // after completion: must be ignored (R10)
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(done == 1 && cmd_valid == 0, "R10", "done held, start ignored",
            {done, cmd_valid}, 2'b10);
        chk(idx == NCMD, "R2", "number of commands", idx, NCMD);
        chk(load_stage == 3, "R9", "refresh load observed", load_stage, 3);
        mon_en = 0;
    endtask

    initial begin
        run_cfg(2'd0, 2'd0, 1'b0, 1'b0, 12'h3A5, 0);
        run_cfg(2'd3, 2'd3, 1'b0, 1'b0, 12'hFFF, 1);
        run_cfg(2'd3, 2'd3, 1'b0, 1'b1, 12'h001, 0);
        run_cfg(2'd2, 2'd1, 1'b1, 1'b0, 12'h5C3, 1);
        run_cfg(2'd1, 2'd2, 1'b1, 1'b1, 12'h800, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule